// File: doc/BRIEF.md
# Cascadable Parallel-Load Serial-Out Shift Register

This block converts parallel words into a serial bit stream. Each device holds eight stages. On every rising clock edge where the active-low clock enable is asserted, the register either captures all of its parallel inputs at once or moves every stage one place toward the far end, taking a new bit from the serial input. The load-or-shift choice is made by an active-low parallel-enable input. While the clock enable is deasserted, the register keeps its value.

Only the last stage is visible, on the serial output. Longer registers are built by feeding one device's far stage into the next device's first stage. A parameter sets how many devices are chained this way. The whole chain then behaves as one register that is eight times that count long.

An active-low master clear acts asynchronously and overrides every other input. The clock enable is treated as a synchronous qualifier sampled at the rising edge. This gives the same result as OR-ing it into the clock, as long as the enable only rises while the clock is high.

Top module: `piso_cascade`

## Requirements
- R1: With `clk_en_n`=0 and `load_n`=0 at a rising edge, every stage takes its parallel input. Stage i of device k takes `par_in[8k+i]`, and `ser_out` shows `par_in[8*N_DEV-1]` after that edge.
- R2: With `clk_en_n`=0 and `load_n`=1 at a rising edge, stage 0 of device 0 takes `ser_in`, and every other flat stage j takes the old value of stage j-1. Device k's stage 7 feeds device k+1's stage 0.
- R3: While `clk_en_n`=1, rising edges change no stage, whatever `load_n`, `ser_in` and `par_in` carry.
- R4: Driving `rst_n` low clears all stages at once, without waiting for a clock edge, so `ser_out` reads 0.
- R5: While `rst_n` stays low, the register stays cleared through clock edges, even when a load is requested.
- R6: The first enabled rising edge after `rst_n` returns high performs a normal load or shift.
- R7: After a load, `ser_out` presents the loaded word highest flat bit first. Bit 8*N_DEV-1-s appears after s shifts, and bits taken from `ser_in` emerge after 8*N_DEV shifts.
- R8: Over any mixed sequence of load, shift, hold and clear, `ser_out` equals the far bit of an 8*N_DEV-bit register updated by R1 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; the register acts on its rising edge |
| rst_n | input | 1 | Active-low asynchronous master clear |
| clk_en_n | input | 1 | Active-low clock enable |
| load_n | input | 1 | Active-low parallel-load select; high selects shifting |
| ser_in | input | 1 | Serial data into stage 0 of the first device |
| par_in | input | 8*N_DEV | Parallel data; bits 8k..8k+7 feed device k |
| ser_out | output | 1 | Far stage of the last device |

## Verification
A word loaded in parallel is shifted out in full, with a different pattern on the serial input. This shows that the bits leave in the right order, that the device boundary is crossed, and that serial bits follow the word. Holding the clock enable high while the load select and data toggle shows whether a disabled edge still loads or shifts. A clear asserted mid-cycle, and held through edges with a load requested, separates asynchronous from synchronous clearing. The edge right after the clear is released checks that the register leaves reset normally. A long seeded random mix of all four operations catches ordering errors that the directed cases miss.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Synchronous action taken by every stage at a rising clock edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

endpackage

// File: rtl/piso_op_decode.sv
module piso_op_decode
    import piso_pkg::*;
(
    input  logic     clk_en_n,
    input  logic     load_n,
    output piso_op_e op
);

    // The clock enable is checked first; load select only matters when enabled
    always_comb begin
        unique case ({clk_en_n, load_n})
            2'b00:   op = OP_LOAD;
            2'b01:   op = OP_SHIFT;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/piso_device.sv
module piso_device
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  piso_op_e         op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic             ser_out
);

    logic [WIDTH-1:0] stages_q;
    logic [WIDTH-1:0] stages_d;

    always_comb begin
        unique case (op)
            OP_LOAD:  stages_d = par_in;
            OP_SHIFT: stages_d = {stages_q[WIDTH-2:0], ser_in};
            default:  stages_d = stages_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stages_q <= '0;
        end else begin
            stages_q <= stages_d;
        end
    end

    assign ser_out = stages_q[WIDTH-1];

endmodule

// File: rtl/piso_cascade.sv
module piso_cascade
    import piso_pkg::*;
#(
    parameter int unsigned N_DEV = 1,
    parameter int unsigned DEV_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clk_en_n,
    input  logic                   load_n,
    input  logic                   ser_in,
    input  logic [N_DEV*DEV_W-1:0] par_in,
    output logic                   ser_out
);

    localparam int unsigned TOTAL_W = N_DEV * DEV_W;

    piso_op_e         op;
    logic [N_DEV:0]   link;

    piso_op_decode u_decode (
        .clk_en_n (clk_en_n),
        .load_n   (load_n),
        .op       (op)
    );

    assign link[0] = ser_in;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        piso_device #(.WIDTH(DEV_W)) u_dev (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op),
            .ser_in  (link[g]),
            .par_in  (par_in[g*DEV_W +: DEV_W]),
            .ser_out (link[g+1])
        );
    end

    assign ser_out = link[N_DEV];

endmodule

// File: rtl/piso_cascade_chk.sv
module piso_cascade_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_en_n,
    input logic load_n,
    input logic par_msb,
    input logic ser_out
);

    // R1: an enabled load puts the top parallel bit on the output
    a_r1_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n) |=> (ser_out == $past(par_msb)));

    // R3: a disabled edge leaves the output unchanged
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(ser_out));

    // R3: a load request while disabled is ignored even if data differs
    a_r3_no_disabled_load: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_n && !load_n && (par_msb != ser_out)) |=> (ser_out == $past(ser_out)));

    // R4, R5: output is clear whenever the master clear is low at an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r5_clear_held: assert (ser_out == 1'b0);
        end
    end

endmodule

bind piso_cascade piso_cascade_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .load_n   (load_n),
    .par_msb  (par_in[N_DEV*DEV_W-1]),
    .ser_out  (ser_out)
);

// File: tb/piso_cascade_bench.sv
`timescale 1ns/1ps
module piso_cascade_bench;

    localparam int unsigned N_DEV = 2;
    localparam int unsigned DEV_W = 8;
    localparam int unsigned W     = N_DEV * DEV_W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_en_n = 1'b1;
    logic         load_n = 1'b1;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] mdl = '0;

    always #2.5 clk = ~clk;

    piso_cascade #(.N_DEV(N_DEV), .DEV_W(DEV_W)) u_piso_cascade (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
        .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out)
    );

    function automatic logic [W-1:0] next_mdl(input logic [W-1:0] cur, input logic en_n,
                                              input logic ld_n, input logic si,
                                              input logic [W-1:0] pi);
        if (en_n)      return cur;
        else if (!ld_n) return pi;
        else           return {cur[W-2:0], si};
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: ser_out=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(input logic en_n, input logic ld_n, input logic si,
                       input logic [W-1:0] pi, input string tag);
        clk_en_n = en_n; load_n = ld_n; ser_in = si; par_in = pi;
        @(posedge clk);
        if (rst_n) mdl = next_mdl(mdl, en_n, ld_n, si, pi);
        @(negedge clk);
        chk(tag, ser_out, mdl[W-1]);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run incomplete, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] word;
        logic [W-1:0] spat;
        void'($urandom(32'd5150));
        repeat (2) @(negedge clk);
        chk("R4 reset state", ser_out, 1'b0);

        // R5: load requested with all ones while clear held
        clk_en_n = 1'b0; load_n = 1'b0; par_in = '1;
        repeat (2) @(negedge clk);
        chk("R5 clear held through edges", ser_out, 1'b0);
        rst_n = 1'b1;
        mdl = '0;

        // R6: first edge after release loads normally
        word = 16'hA5C3;
        cyc(1'b0, 1'b0, 1'b0, word, "R6 first edge after release");
        chk("R1 load msb", ser_out, word[W-1]);

        // R7 and R2: shift out word, then the serial pattern follows
        spat = 16'h3B19;
        for (int s = 1; s < W; s++) begin
            cyc(1'b0, 1'b1, spat[s-1], '0, "R2 shift");
            chk("R7 word order", ser_out, word[W-1-s]);
        end
        for (int s = 0; s < 4; s++) begin
            cyc(1'b0, 1'b1, spat[W-1+s], '0, "R2 shift");
            chk("R7 serial entry", ser_out, spat[s]);
        end

        // R3: disabled edges with load requested and data toggling
        for (int s = 0; s < 6; s++) begin
            cyc(1'b1, s[0], ~ser_out, ~mdl, "R3 disabled edge");
        end
        cyc(1'b0, 1'b1, 1'b0, '0, "R3 state kept after hold");

        // R4: clear mid-cycle, observed before any edge
        cyc(1'b0, 1'b0, 1'b0, 16'h8001, "R1 load");
        #1 rst_n = 1'b0;
        #0.5;
        chk("R4 async clear", ser_out, 1'b0);
        mdl = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8: seeded random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 63) == 0) begin
                rst_n = 1'b0;
                #1;
                mdl = '0;
                chk("R4 random clear", ser_out, 1'b0);
                @(negedge clk);
                rst_n = 1'b1;
            end else begin
                cyc(($urandom_range(0, 3) == 0), ($urandom_range(0, 4) != 0),
                    1'($urandom), W'($urandom), "R8 random");
            end
        end

        summary();
        $finish;
    end

endmodule